// File: doc/BRIEF.md
# GPIO Port with Keyed Self-Test Readback

This block is one 8-bit general-purpose I/O port that sits on a simple processor register bus. The bus has write and read strobes, an address and an 8-bit data path. The port holds five registers: an output latch, a direction register, a pull-up enable register, a wake-up select register and a self-test key register. It drives the output value, output enable and pull-up enable of each pad. It samples the pad inputs through a multi-stage synchroniser.

In normal operation, a read of the port address returns one of two values for each pin. For a pin set as output it returns the latch bit. For a pin set as input it returns the synchronised pin level. The key register holds one 8-bit code. While it holds exactly 0xCA, the port enters a diagnostic mode. In that mode a read of the port address returns the synchronised pin levels on every pin, whatever each pin's direction. This lets a self-test compare what was driven with what actually reached the pad.

A port built with wake-up support raises a one-cycle wake request when a selected input falls. A port built without it never raises the request.

Top module: `gpio_port_selftest`

## Requirements
- R1: After reset, the output latch, the pull-up register, the wake-up select register and the key register are 0x00. The direction register is 0xFF (all inputs), so pad_oe, pad_out and pad_pu are all 0x00 and diag_active is 0.
- R2: Addresses are 0 = port latch, 1 = direction, 2 = pull-up enable, 3 = wake-up select, 4 = self-test key. A write with wr_en stores wdata. A read with rd_en loads rdata at that clock edge. For addresses 1 to 4, the read returns the stored register.
- R3: diag_active is 1 exactly while the key register holds 8'hCA. Every other value, including each value one bit away from 8'hCA, gives 0.
- R4: While diag_active is 1, a read of address 0 returns the synchronised pad_in level on every bit, including bits set as outputs.
- R5: While diag_active is 0, a read of address 0 returns the latch bit for each bit whose direction bit is 0 (output). It returns the synchronised pad_in bit for each bit whose direction bit is 1 (input).
- R6: pad_out equals the output latch. pad_oe bit i is 1 exactly when direction bit i is 0.
- R7: pad_pu bit i is 1 only when pull-up bit i is 1 and direction bit i is 1. A pin set as output never has its pull-up on.
- R8: With wake-up support, wake_req pulses for one cycle for each falling edge of a synchronised input whose select bit is 1. Rising edges, and edges on unselected bits, do not raise it.
- R9: A port built without wake-up support holds wake_req at 0 for any input activity.
- R10: Addresses 5 to 7 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad weak pull-up enables |
| diag_active | output | 1 | Diagnostic readback mode is armed |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The case that is hardest to produce from the ports is a pin set as output whose pad level disagrees with its latch. Only that case separates diagnostic readback from normal readback. The bench makes every pin an output with the latch at 0x00 and holds pad_in at 0xFF. It then sweeps all 256 key values. For each value it reads the port and expects 0xFF only for 0xCA. This covers every single-bit neighbour of the key. Wake-up edges are counted over a window rather than at a fixed cycle. That window spans the synchroniser delay.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    A_PORT = 3'd0,
    A_DIR  = 3'd1,
    A_PULL = 3'd2,
    A_WSEL = 3'd3,
    A_KEY  = 3'd4
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] pin,
  output logic         wake
);
  logic [W-1:0] prev_q;
  logic [W-1:0] fall;

  assign fall = sel & prev_q & ~pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      wake   <= 1'b0;
    end else begin
      prev_q <= pin;
      wake   <= |fall;
    end
  end

  // R8: a request only follows a cycle with some selected bit
  p_wake_needs_sel_r8: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(sel) != '0));
  // R8: a request is a single-cycle pulse when the pin set is static
  p_wake_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (wake && $stable(pin)) |=> !wake);
endmodule

// File: rtl/gpio_port_selftest.sv
module gpio_port_selftest
  import gpio_pkg::*;
#(
  parameter int          W           = 8,
  parameter int          SYNC_STAGES = 2,
  parameter bit          HAS_WAKE    = 1'b1,
  parameter logic [7:0]  DIAG_KEY    = 8'hCA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic         diag_active,
  output logic         wake_req
);
  localparam logic [W-1:0] ALL_IN = {W{1'b1}};

  logic [W-1:0] latch_q, dir_q, pull_q, wsel_q, key_q, rd_q;
  logic         diag_q;
  logic [W-1:0] pin_s;
  logic [W-1:0] rd_mux;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (pad_in), .dout (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= ALL_IN;
      pull_q  <= '0;
      wsel_q  <= '0;
      key_q   <= '0;
      diag_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_PORT: latch_q <= wdata;
        A_DIR:  dir_q   <= wdata;
        A_PULL: pull_q  <= wdata;
        A_WSEL: wsel_q  <= wdata;
        A_KEY: begin
          key_q  <= wdata;
          diag_q <= (wdata[7:0] == DIAG_KEY);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_PORT:  rd_mux = diag_q ? pin_s : ((dir_q & pin_s) | (~dir_q & latch_q));
      A_DIR:   rd_mux = dir_q;
      A_PULL:  rd_mux = pull_q;
      A_WSEL:  rd_mux = wsel_q;
      A_KEY:   rd_mux = key_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rdata       = rd_q;
  assign pad_out     = latch_q;
  assign pad_oe      = ~dir_q;
  assign pad_pu      = pull_q & dir_q;
  assign diag_active = diag_q;

  generate
    if (HAS_WAKE) begin : g_wake
      gpio_wake #(.W(W)) u_wake (
        .clk (clk), .rst (rst), .sel (wsel_q), .pin (pin_s), .wake (wake_req)
      );
    end else begin : g_nowake
      assign wake_req = 1'b0;
    end
  endgenerate

  // R3: mode flag agrees with the stored key at all times
  p_diag_key_r3: assert property (@(posedge clk) disable iff (rst)
    diag_active == (key_q[7:0] == DIAG_KEY));
  // R4: diagnostic port read returns the synchronised pins
  p_diag_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_PORT && diag_active) |=> (rdata == $past(pin_s)));
  // R6: a latch write appears on the pad outputs next cycle
  p_latch_out_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PORT) |=> (pad_out == $past(wdata)));
  // R7: a pull-up write is masked by the direction on the pads
  p_pull_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_PULL) |=> (pad_pu == ($past(wdata) & ~pad_oe)));
  // R10: unmapped reads return zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > 3'd4) |=> (rdata == '0));
endmodule

// File: tb/sim_gpio_port_selftest.sv
module sim_gpio_port_selftest;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe, pad_pu, rdata1, out1, oe1, pu1;
  logic       diag_active, wake_req, diag1, wake1;
  int checks = 0, fails = 0, wake_cnt = 0, wake1_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port_selftest u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .diag_active(diag_active), .wake_req(wake_req)
  );

  gpio_port_selftest #(.HAS_WAKE(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata1), .pad_in(pad_in), .pad_out(out1),
    .pad_oe(oe1), .pad_pu(pu1), .diag_active(diag1), .wake_req(wake1)
  );

  always @(negedge clk) begin
    if (!rst && wake_req) wake_cnt++;
    if (!rst && wake1) wake1_cnt++;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ex;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 diag", {7'd0, diag_active}, 8'h00);
    rd(3'd1, v); chk("R1 dir", v, 8'hFF);
    rd(3'd2, v); chk("R1 pull", v, 8'h00);
    rd(3'd3, v); chk("R1 wsel", v, 8'h00);
    rd(3'd4, v); chk("R1 key", v, 8'h00);
    rd(3'd0, v); chk("R1 port", v, 8'h00);

    // R2 register readback, a few patterns
    for (int i = 0; i < 4; i++) begin
      for (int a = 1; a <= 3; a++) begin
        ex = 8'(i * 77 + a * 19);
        wr(3'(a), ex); rd(3'(a), v); chk("R2 readback", v, ex);
      end
    end

    // R6 / R7 outputs over direction and pull patterns
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d, p, l;
      d = 8'(i * 53 + 5); p = 8'(i * 29 + 170); l = 8'(i * 91 + 3);
      wr(3'd1, d); wr(3'd2, p); wr(3'd0, l);
      chk("R6 pad_out", pad_out, l);
      chk("R6 pad_oe", pad_oe, ~d);
      chk("R7 pad_pu", pad_pu, p & d);
    end
    wr(3'd2, 8'hFF); wr(3'd1, 8'h00);
    chk("R7 outputs no pullup", pad_pu, 8'h00);

    // R5 normal readback mix of latch and pin
    for (int i = 0; i < 12; i++) begin
      logic [7:0] d, l, p;
      d = 8'(i * 37 + 11); l = 8'(i * 101 + 7); p = 8'(i * 59 + 200);
      wr(3'd1, d); wr(3'd0, l); pad_in = p; settle();
      rd(3'd0, v);
      chk("R5 normal read", v, (l & ~d) | (p & d));
    end

    // R3 / R4 / R2 sweep of all key values with outputs disagreeing with pins
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); pad_in = 8'hFF; settle();
    for (int k = 0; k < 256; k++) begin
      wr(3'd4, 8'(k));
      chk("R3 diag flag", {7'd0, diag_active}, (k == 8'hCA) ? 8'h01 : 8'h00);
      rd(3'd0, v);
      chk("R4 port read", v, (k == 8'hCA) ? 8'hFF : 8'h00);
      rd(3'd4, v);
      chk("R2 key readback", v, 8'(k));
    end
    // R4 diag mixed direction and pattern
    wr(3'd4, 8'hCA); wr(3'd1, 8'h0F); wr(3'd0, 8'h5A); pad_in = 8'h3C; settle();
    rd(3'd0, v); chk("R4 diag mixed", v, 8'h3C);
    wr(3'd4, 8'hCB);
    rd(3'd0, v); chk("R3 leave diag", v, (8'h5A & 8'hF0) | (8'h3C & 8'h0F));

    // R10 unmapped
    wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'h00);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), v); chk("R10 unmapped read", v, 8'h00);
    end
    rd(3'd1, v); chk("R10 dir kept", v, 8'hA5);
    rd(3'd2, v); chk("R10 pull kept", v, 8'h3C);
    rd(3'd3, v); chk("R10 wsel kept", v, 8'h00);
    rd(3'd4, v); chk("R10 key kept", v, 8'hCB);

    // R8 wake-up edges
    wr(3'd1, 8'hFF); pad_in = 8'hFF; settle();
    wr(3'd3, 8'h01); settle();
    wake_cnt = 0; pad_in = 8'hFE; repeat (8) @(negedge clk);
    chk("R8 selected fall", 8'(wake_cnt), 8'd1);
    wake_cnt = 0; pad_in = 8'hFC; repeat (8) @(negedge clk);
    chk("R8 unselected fall", 8'(wake_cnt), 8'd0);
    wake_cnt = 0; pad_in = 8'hFF; repeat (8) @(negedge clk);
    chk("R8 rising", 8'(wake_cnt), 8'd0);
    wr(3'd3, 8'hF0); settle();
    wake_cnt = 0; pad_in = 8'h0F; repeat (8) @(negedge clk);
    chk("R8 multi fall one pulse", 8'(wake_cnt), 8'd1);

    // R9 no-wake build never requested
    chk("R9 no wake", 8'(wake1_cnt), 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule